// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It owns the command bus from reset until the memory is ready for normal traffic. It holds the clock enable low while the clock settles. It then wakes the device and issues, in a fixed order, a precharge of all banks, an extended mode write that enables the DLL, and a mode write that resets the DLL. After the DLL lock time it issues a second precharge of all banks, a train of auto-refreshes, and a closing mode write that sets the burst length, burst type and a read latency of three.

Every cycle that does not carry one of these commands carries a NOP. The clock frequency enters as a parameter in MHz. The block multiplies it by the stable-clock time in microseconds to get the length of the first wait. The other gaps are parameters counted in clock cycles. When the last mode write has had its settle time, the block raises a ready flag. It keeps the flag high, and drives only NOPs, until the next reset.

The command is read from the four active-low strobes in the order {cs_n, ras_n, cas_n, we_n}. A NOP is 0111, a precharge is 0010, an auto-refresh is 0001 and a mode or extended-mode write is 0000. All outputs are decoded from registered state, and the block has no data path.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset, and for STABLE_US*CLK_MHZ cycles after reset is released, cke is 0 and the command is NOP (0111) with ba and addr at zero.
- R2: In the cycle right after the stable wait, cke is 1 and the command is NOP. From then on, cke stays 1 until the next reset.
- R3: One cycle after the wake NOP, a precharge of all banks is issued: command 0010, addr bit 10 is 1, all other addr bits are 0, and ba is 00.
- R4: T_RP cycles after the first precharge, an extended mode write is issued: command 0000, ba=01, addr bit 0=0 (DLL on), addr bit 1=DRV_CODE[0], addr bit 6=DRV_CODE[1], and every other addr bit is 0.
- R5: T_MRD cycles after the extended mode write, a mode write with DLL reset is issued: command 0000, ba=00, addr[2:0]=BL_CODE, addr[3]=BT_CODE, addr[6:4]=011, addr[7]=0, addr[8]=1, addr[11:9]=0.
- R6: The second precharge of all banks (encoded as in R3) comes max(DLL_LOCK_CYC, T_MRD) cycles after the DLL-reset mode write.
- R7: N_REFRESH auto-refreshes (command 0001, ba and addr zero) follow. The first comes T_RP cycles after the second precharge, and the others are each T_RFC cycles after the one before.
- R8: T_RFC cycles after the last refresh, the final mode write is issued. It is encoded as in R5 except that addr[8]=0.
- R9: Every cycle that carries none of the commands in R3 to R8 carries a NOP with ba=00 and addr=0. A mode write is always followed by a NOP cycle.
- R10: init_done is 0 until T_MRD cycles after the final mode write. It then rises and stays 1 until reset, and no command other than NOP is issued after that.
- R11: Asserting reset at any point returns every output to its R1 state, and the whole sequence restarts after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, the same clock forwarded to the memory |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address; selects the extended mode register during an extended mode write |
| addr | output | 12 | Address bus carrying the precharge-all bit and the mode register fields |
| init_done | output | 1 | High once the initialization order is complete |

## Verification
The bench builds the sequencer with CLK_MHZ=2 and STABLE_US=10, so the stable wait lasts 20 cycles instead of 50,000. This keeps the complete order, and a second pass after a reset in the middle of the sequence, inside a short run. It uses T_RP=3, T_MRD=2, T_RFC=5, a DLL lock time of 12 and N_REFRESH=3. These distinct gaps place every command at its own cycle, and the third refresh exercises the refresh loop beyond the minimum of two. It selects burst length code 010, the interleaved burst type and driver code 01, so that the variable mode-register bits are nonzero and each can be seen in its own position.

// File: rtl/ddr_init_pkg.sv
`timescale 1ns/1ps
package ddr_init_pkg;

  // Sequencer steps, in issue order.
  typedef enum logic [3:0] {
    ST_STABLE,
    ST_WAKE,
    ST_PRE_A,
    ST_EMRS,
    ST_MRS_DLL,
    ST_PRE_B,
    ST_REF,
    ST_MRS_RUN,
    ST_DONE
  } init_step_e;

  // Command strobes {cs_n, ras_n, cas_n, we_n}.
  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_PRE  = 4'b0010;
  localparam logic [3:0] CMD_REF  = 4'b0001;
  localparam logic [3:0] CMD_MODE = 4'b0000;

  // Read latency code for three cycles.
  localparam logic [2:0] LAT3_CODE = 3'b011;

endpackage

// File: rtl/ddr_init_timer.sv
`timescale 1ns/1ps
module ddr_init_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] span,
  output logic             first,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  assign first = (cnt == '0);
  assign last  = (cnt == span - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (last) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // The step counter never runs past the span of the step it times (R7 gaps rely on it).
  assert_cnt_in_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < span);

endmodule

// File: rtl/ddr_init_cmd_enc.sv
`timescale 1ns/1ps
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter logic [2:0] BL_CODE  = 3'b010,
  parameter logic       BT_CODE  = 1'b0,
  parameter logic [1:0] DRV_CODE = 2'b00,
  parameter int         ADDR_W   = 12,
  parameter int         BA_W     = 2
) (
  input  init_step_e        step,
  input  logic              first,
  output logic              cke,
  output logic [3:0]        cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  localparam int AP_BIT  = 10;
  localparam int DLL_BIT = 8;

  logic [ADDR_W-1:0] mode_word;

  always_comb begin
    mode_word        = '0;
    mode_word[2:0]   = BL_CODE;
    mode_word[3]     = BT_CODE;
    mode_word[6:4]   = LAT3_CODE;
  end

  always_comb begin
    cke  = (step != ST_STABLE);
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    if (first) begin
      unique case (step)
        ST_PRE_A, ST_PRE_B: begin
          cmd          = CMD_PRE;
          addr[AP_BIT] = 1'b1;
        end
        ST_EMRS: begin
          cmd     = CMD_MODE;
          ba      = BA_W'(1);
          addr[1] = DRV_CODE[0];
          addr[6] = DRV_CODE[1];
        end
        ST_MRS_DLL: begin
          cmd           = CMD_MODE;
          addr          = mode_word;
          addr[DLL_BIT] = 1'b1;
        end
        ST_REF:     cmd = CMD_REF;
        ST_MRS_RUN: begin
          cmd  = CMD_MODE;
          addr = mode_word;
        end
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddr_init_seq.sv
`timescale 1ns/1ps
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int         CLK_MHZ      = 250,
  parameter int         STABLE_US    = 200,
  parameter int         DLL_LOCK_CYC = 200,
  parameter int         T_RP         = 3,
  parameter int         T_RFC        = 12,
  parameter int         T_MRD        = 2,
  parameter int         N_REFRESH    = 2,
  parameter logic [2:0] BL_CODE      = 3'b010,
  parameter logic       BT_CODE      = 1'b0,
  parameter logic [1:0] DRV_CODE     = 2'b00
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        cke,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [1:0]  ba,
  output logic [11:0] addr,
  output logic        init_done
);

  localparam int STABLE_CYC = STABLE_US * CLK_MHZ;
  localparam int DLL_SPAN   = (DLL_LOCK_CYC > T_MRD) ? DLL_LOCK_CYC : T_MRD;
  localparam int MAX_A      = (STABLE_CYC > DLL_SPAN) ? STABLE_CYC : DLL_SPAN;
  localparam int MAX_B      = (T_RFC > T_RP) ? T_RFC : T_RP;
  localparam int MAX_SPAN   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W      = $clog2(MAX_SPAN + 1);
  localparam int REF_W      = $clog2(N_REFRESH + 1);

  init_step_e       step;
  logic [REF_W-1:0] ref_cnt;
  logic [CNT_W-1:0] span;
  logic             first, last;
  logic [3:0]       cmd;

  always_comb begin
    unique case (step)
      ST_STABLE:            span = CNT_W'(STABLE_CYC);
      ST_PRE_A, ST_PRE_B:   span = CNT_W'(T_RP);
      ST_EMRS, ST_MRS_RUN:  span = CNT_W'(T_MRD);
      ST_MRS_DLL:           span = CNT_W'(DLL_SPAN);
      ST_REF:               span = CNT_W'(T_RFC);
      default:              span = CNT_W'(1);
    endcase
  end

  ddr_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .span  (span),
    .first (first),
    .last  (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step    <= ST_STABLE;
      ref_cnt <= '0;
    end else if (last) begin
      unique case (step)
        ST_STABLE:  step <= ST_WAKE;
        ST_WAKE:    step <= ST_PRE_A;
        ST_PRE_A:   step <= ST_EMRS;
        ST_EMRS:    step <= ST_MRS_DLL;
        ST_MRS_DLL: step <= ST_PRE_B;
        ST_PRE_B: begin
          step    <= ST_REF;
          ref_cnt <= '0;
        end
        ST_REF: begin
          ref_cnt <= ref_cnt + 1'b1;
          if (ref_cnt == REF_W'(N_REFRESH - 1)) step <= ST_MRS_RUN;
        end
        ST_MRS_RUN: step <= ST_DONE;
        default:    step <= ST_DONE;
      endcase
    end
  end

  ddr_init_cmd_enc #(
    .BL_CODE  (BL_CODE),
    .BT_CODE  (BT_CODE),
    .DRV_CODE (DRV_CODE),
    .ADDR_W   (12),
    .BA_W     (2)
  ) u_enc (
    .step  (step),
    .first (first),
    .cke   (cke),
    .cmd   (cmd),
    .ba    (ba),
    .addr  (addr)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign init_done = (step == ST_DONE);

  // Ready never shows while the clock enable is still low.
  assert_ready_after_wake_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> !init_done);

  // Clock enable never drops outside reset.
  assert_cke_no_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(cke));

  // The wake cycle carries a NOP.
  assert_wake_is_nop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (!cs_n && ras_n && cas_n && we_n));

  // Ready is sticky and the bus is idle once raised.
  assert_ready_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> (init_done && !cs_n && ras_n && cas_n && we_n));

  generate
    if (T_MRD >= 2) begin : g_mrd_chk
      // A mode write is followed by at least one NOP cycle.
      assert_mode_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n && !we_n) |=> (!cs_n && ras_n && cas_n && we_n));
    end
  endgenerate

endmodule

// File: tb/ddr_init_seq_bench.sv
`timescale 1ns/1ps
module ddr_init_seq_bench;

  localparam int CLK_MHZ = 2;
  localparam int STAB_US = 10;
  localparam int DLL_LK  = 12;
  localparam int TRP     = 3;
  localparam int TRFC    = 5;
  localparam int TMRD    = 2;
  localparam int NREF    = 3;
  localparam logic [2:0] BL = 3'b010;
  localparam logic       BT = 1'b1;
  localparam logic [1:0] DRV = 2'b01;

  // Expected timeline, in cycles after reset release.
  localparam int S      = STAB_US * CLK_MHZ;
  localparam int C_PRE1 = S + 1;
  localparam int C_EMRS = C_PRE1 + TRP;
  localparam int C_MDLL = C_EMRS + TMRD;
  localparam int C_PRE2 = C_MDLL + ((DLL_LK > TMRD) ? DLL_LK : TMRD);
  localparam int C_REF0 = C_PRE2 + TRP;
  localparam int C_MRUN = C_REF0 + NREF * TRFC;
  localparam int C_DONE = C_MRUN + TMRD;
  localparam int NEXP   = 5 + NREF;
  localparam int NCYC   = C_DONE + 20;

  localparam logic [11:0] A_PRE  = 12'h400;
  localparam logic [11:0] A_EMRS = {5'b0, DRV[1], 4'b0, DRV[0], 1'b0};
  localparam logic [11:0] A_MRUN = {3'b000, 1'b0, 1'b0, 3'b011, BT, BL};
  localparam logic [11:0] A_MDLL = A_MRUN | 12'h100;

  // Vector: {cycle[15:0], cmd[3:0], ba[1:0], addr[11:0]}
  localparam logic [33:0] EXP [NEXP] = '{
    {16'(C_PRE1), 4'b0010, 2'b00, A_PRE},
    {16'(C_EMRS), 4'b0000, 2'b01, A_EMRS},
    {16'(C_MDLL), 4'b0000, 2'b00, A_MDLL},
    {16'(C_PRE2), 4'b0010, 2'b00, A_PRE},
    {16'(C_REF0), 4'b0001, 2'b00, 12'h000},
    {16'(C_REF0 + TRFC), 4'b0001, 2'b00, 12'h000},
    {16'(C_REF0 + 2*TRFC), 4'b0001, 2'b00, 12'h000},
    {16'(C_MRUN), 4'b0000, 2'b00, A_MRUN}
  };
  // Requirement of each vector: R3, R4, R5, R6, R7, R7, R7, R8
  localparam int EXP_REQ [NEXP] = '{3, 4, 5, 6, 7, 7, 7, 8};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0]  ba;
  logic [11:0] addr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ddr_init_seq #(
    .CLK_MHZ(CLK_MHZ), .STABLE_US(STAB_US), .DLL_LOCK_CYC(DLL_LK),
    .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD), .N_REFRESH(NREF),
    .BL_CODE(BL), .BT_CODE(BT), .DRV_CODE(DRV)
  ) u_ddr_init_seq (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done)
  );

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Idle outputs as in R1 (reset state / stable wait).
  task automatic check_idle(input string req, input logic exp_cke);
    check(req, {16'(cke), 4'({cs_n, ras_n, cas_n, we_n}), ba, addr},
               {16'(exp_cke), 4'b0111, 2'b00, 12'h000});
  endtask

  // Release reset and walk ncyc cycles; a full run must match every vector.
  task automatic run_seq(input int ncyc, input bit full);
    int ncap = 0;
    @(negedge clk) rst_n = 1'b1;
    for (int k = 0; k < ncyc; k++) begin
      logic [3:0] c;
      c = {cs_n, ras_n, cas_n, we_n};
      if (k < S) check_idle("R1", 1'b0);
      if (k == S) check_idle("R2", 1'b1);
      if (k > S && cke !== 1'b1) check("R2", 34'(cke), 34'd1);
      if (c != 4'b0111) begin
        if (ncap < NEXP) begin
          check($sformatf("R%0d", EXP_REQ[ncap]),
                {16'(k), c, ba, addr}, EXP[ncap]);
        end else begin
          check("R10", {16'(k), c, ba, addr}, {16'(k), 4'b0111, 2'b00, 12'h000});
        end
        ncap++;
      end else if (ba != 2'b00 || addr != 12'h000) begin
        check("R9", {20'h0, ba, addr}, 34'h0);
      end
      if (init_done !== (k >= C_DONE)) check("R10", 34'(init_done), 34'(k >= C_DONE));
      if (k == C_DONE - 1 || k == C_DONE || k == ncyc - 1)
        check("R10", 34'(init_done), 34'(k >= C_DONE));
      @(negedge clk);
    end
    if (full) check("R10", 34'(ncap), 34'(NEXP));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1", 1'b0);
    check("R1", 34'(init_done), 34'd0);
    run_seq(NCYC, 1'b1);
    // Reset after completion: back to R1 state (R11).
    rst_n = 1'b0;
    #1;
    check_idle("R11", 1'b0);
    check("R11", 34'(init_done), 34'd0);
    repeat (2) @(negedge clk);
    // Partial run, then reset in the middle of the DLL lock wait (R11).
    run_seq(C_MDLL + 4, 1'b0);
    rst_n = 1'b0;
    #1;
    check_idle("R11", 1'b0);
    repeat (2) @(negedge clk);
    run_seq(NCYC, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule